// File: doc/BRIEF.md
# Oscillator Frequency Measurement Sequencer

This controller runs a complete campaign of oscillator frequency readouts. A bank of counted oscillators and one reference oscillator sit beside it. Each counter is clocked only by its own oscillator. For every measurement the sequencer first clears the counters. It does this by raising the counter reset while briefly running all oscillators, so that each counter sees edges on its own clock. It then runs the selected oscillators and the reference for a programmed number of system clocks. Finally it streams the frozen counts, one word per clock, through a multiplexer into a collection buffer.

A mode field chooses parallel operation or serial operation. In parallel operation every oscillator runs at once and each readout yields all counts followed by the reference count. In serial operation the oscillators run one at a time, each followed by a reference count. The same mode field can enable warm-up readout sets whose data is discarded, and an idle cooldown gap after every measurement. Between measurements the block decides whether the buffer may drain to memory, based on its fill level. The drain permission is always withheld while any oscillator runs. A sticky done flag signals the end of the campaign.

Top module: `osc_meas_seq`

## Requirements
- R1: A `start_i` pulse in idle begins a campaign; a `start_i` pulse while a campaign runs has no effect on its data stream or its length.
- R2: Every measurement begins with `cnt_rst_o` high for exactly 17 consecutive clocks (one init clock plus 16 wait clocks). During those clocks every bit of `osc_en_o` and `ref_en_o` is high.
- R3: After the reset phase, the selected oscillators and the reference are enabled with `cnt_rst_o` low for exactly `eval_i` clocks (a value of 0 is treated as 1), then all enables drop.
- R4: In parallel mode (`mode_i[0]`=1), each stored readout emits NUM_OSC+1 words with `data_en_o` high: the counts of oscillators 0 to NUM_OSC-1 in index order, then the reference count. No oscillator is enabled while words are sent.
- R5: In serial mode (`mode_i[0]`=0), at most one oscillator is enabled at a time. Each readout is NUM_OSC measurements, for oscillators 0 to NUM_OSC-1 in turn, and each emits two words: that oscillator's count, then the reference count.
- R6: With `mode_i[1]`=1, the first `heatup_i` readout sets run normally but assert no `data_en_o`. With `mode_i[1]`=0, `heatup_i` is ignored.
- R7: With `mode_i[2]`=1 and `cool_i`>0, every measurement is followed by `cool_i` idle clocks. With `mode_i[2]`=0, `cool_i` is ignored.
- R8: `xfer_permit_o` is re-decided once per measurement in the check state; the decision is true only if `buf_level_i` is strictly greater than 256. The output is low whenever any oscillator or the reference is enabled.
- R9: When the stored-readout count reaches `readouts_i`, `done_irq_o` rises in the clock after the check state and stays high until the next accepted start. A campaign of M measurements, each of length L, raises it M*L+1 clocks after start is sampled.
- R10: Mode, readout count, evaluation time, heatup count and cooldown are captured at start; changes to them during a campaign have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Campaign start pulse |
| mode_i | input | 3 | Bit 0 parallel, bit 1 heatup enable, bit 2 cooldown enable |
| readouts_i | input | PRM_W | Number of stored readout sets |
| eval_i | input | PRM_W | Evaluation window in clocks |
| heatup_i | input | PRM_W | Readout sets discarded at start |
| cool_i | input | PRM_W | Idle clocks after each measurement |
| buf_level_i | input | LVL_W | Words currently held in the collection buffer |
| osc_cnt_i | input | NUM_OSC*CNT_W | Packed oscillator counter values, oscillator 0 in the low bits |
| ref_cnt_i | input | CNT_W | Reference counter value |
| osc_en_o | output | NUM_OSC | Oscillator enables |
| ref_en_o | output | 1 | Reference oscillator enable |
| cnt_rst_o | output | 1 | Synchronous counter reset |
| data_o | output | CNT_W | Selected count toward the buffer |
| data_en_o | output | 1 | Buffer write enable |
| xfer_permit_o | output | 1 | Buffer may drain to memory |
| done_irq_o | output | 1 | Campaign complete, sticky |

## Verification
The bench models each oscillator as a counter with its own rate that counts only while enabled and clears only when reset and enable are both high. A sequencer that dropped the enables during reset therefore leaves stale counts in the next readout. The bench compares every emitted word against a queue built from the requirements, so a mux that selects the wrong index, or a reference word missing after a serial measurement, shows up as a value mismatch. A zero evaluation time, the fill level at exactly 256 and at 257, a campaign with zero readouts, and a restart pulse with changed parameters mid-run are each targeted. A design that mis-handles any of these either miscounts the clocks to the done flag or emits an extra or missing word.

// File: rtl/osc_meas_pkg.sv
package osc_meas_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_RINIT,
        ST_RWAIT,
        ST_EVAL,
        ST_SEND,
        ST_COOL
    } seq_state_e;

    localparam int MODE_PAR  = 0;
    localparam int MODE_HEAT = 1;
    localparam int MODE_COOL = 2;

endpackage

// File: rtl/osc_meas_timer.sv
module osc_meas_timer #(
    parameter int TW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [TW-1:0] load_val_i,
    output logic          zero_o
);
    logic [TW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i)
            cnt_d = load_val_i;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/osc_meas_mux.sv
module osc_meas_mux #(
    parameter int NUM_OSC = 32,
    parameter int CNT_W   = 32,
    parameter int IDX_W   = $clog2(NUM_OSC + 1)
) (
    input  logic [NUM_OSC*CNT_W-1:0] osc_cnt_i,
    input  logic [CNT_W-1:0]         ref_cnt_i,
    input  logic [IDX_W-1:0]         idx_i,
    output logic [CNT_W-1:0]         data_o
);
    logic [CNT_W-1:0] words [NUM_OSC+1];

    for (genvar g = 0; g < NUM_OSC; g++) begin : g_unpack
        assign words[g] = osc_cnt_i[g*CNT_W +: CNT_W];
    end
    assign words[NUM_OSC] = ref_cnt_i;

    always_comb begin
        data_o = ref_cnt_i;
        if (32'(idx_i) <= NUM_OSC)
            data_o = words[idx_i];
    end

endmodule

// File: rtl/osc_meas_seq.sv
module osc_meas_seq
    import osc_meas_pkg::*;
#(
    parameter int NUM_OSC      = 32,
    parameter int CNT_W        = 32,
    parameter int PRM_W        = 32,
    parameter int LVL_W        = 11,
    parameter int DRAIN_THRESH = 256,
    parameter int RST_CYCLES   = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start_i,
    input  logic [2:0]               mode_i,
    input  logic [PRM_W-1:0]         readouts_i,
    input  logic [PRM_W-1:0]         eval_i,
    input  logic [PRM_W-1:0]         heatup_i,
    input  logic [PRM_W-1:0]         cool_i,
    input  logic [LVL_W-1:0]         buf_level_i,
    input  logic [NUM_OSC*CNT_W-1:0] osc_cnt_i,
    input  logic [CNT_W-1:0]         ref_cnt_i,
    output logic [NUM_OSC-1:0]       osc_en_o,
    output logic                     ref_en_o,
    output logic                     cnt_rst_o,
    output logic [CNT_W-1:0]         data_o,
    output logic                     data_en_o,
    output logic                     xfer_permit_o,
    output logic                     done_irq_o
);
    localparam int SEL_W = $clog2(NUM_OSC);
    localparam int WRD_W = $clog2(NUM_OSC + 1);
    localparam logic [WRD_W-1:0] REF_IDX  = WRD_W'(NUM_OSC);
    localparam logic [SEL_W-1:0] SEL_LAST = SEL_W'(NUM_OSC - 1);

    typedef struct packed {
        seq_state_e       state;
        logic             par;
        logic             cool_en;
        logic [PRM_W-1:0] readouts;
        logic [PRM_W-1:0] eval;
        logic [PRM_W-1:0] cool;
        logic [PRM_W-1:0] heat_left;
        logic [PRM_W-1:0] done_cnt;
        logic [SEL_W-1:0] sel;
        logic [WRD_W-1:0] word;
        logic             grant;
        logic             irq;
    } seq_regs_t;

    seq_regs_t        d, q;
    logic             tmr_load, tmr_zero;
    logic [PRM_W-1:0] tmr_val;
    logic [WRD_W-1:0] last_word, mux_idx;
    logic             set_done, active;

    always_comb begin
        d         = q;
        tmr_load  = 1'b0;
        tmr_val   = '0;
        set_done  = 1'b0;
        last_word = q.par ? REF_IDX : WRD_W'(1);
        case (q.state)
            ST_IDLE: if (start_i) begin
                d.state     = ST_CHECK;
                d.par       = mode_i[MODE_PAR];
                d.cool_en   = mode_i[MODE_COOL];
                d.readouts  = readouts_i;
                d.eval      = eval_i;
                d.cool      = cool_i;
                d.heat_left = mode_i[MODE_HEAT] ? heatup_i : '0;
                d.done_cnt  = '0;
                d.sel       = '0;
                d.word      = '0;
                d.irq       = 1'b0;
            end
            ST_CHECK: begin
                d.grant = (32'(buf_level_i) > DRAIN_THRESH);
                if (q.done_cnt == q.readouts) begin
                    d.irq   = 1'b1;
                    d.state = ST_IDLE;
                end else begin
                    d.state = ST_RINIT;
                end
            end
            ST_RINIT: begin
                d.state  = ST_RWAIT;
                tmr_load = 1'b1;
                tmr_val  = PRM_W'(RST_CYCLES - 1);
            end
            ST_RWAIT: if (tmr_zero) begin
                d.state  = ST_EVAL;
                tmr_load = 1'b1;
                tmr_val  = (q.eval == '0) ? '0 : q.eval - 1'b1;
            end
            ST_EVAL: if (tmr_zero) begin
                d.state = ST_SEND;
                d.word  = '0;
            end
            ST_SEND: begin
                if (q.word == last_word) begin
                    d.word   = '0;
                    set_done = q.par || (q.sel == SEL_LAST);
                    if (!q.par)
                        d.sel = (q.sel == SEL_LAST) ? '0 : q.sel + 1'b1;
                    if (set_done) begin
                        if (q.heat_left != '0) d.heat_left = q.heat_left - 1'b1;
                        else                   d.done_cnt  = q.done_cnt + 1'b1;
                    end
                    if (q.cool_en && q.cool != '0) begin
                        d.state  = ST_COOL;
                        tmr_load = 1'b1;
                        tmr_val  = q.cool - 1'b1;
                    end else begin
                        d.state = ST_CHECK;
                    end
                end else begin
                    d.word = q.word + 1'b1;
                end
            end
            ST_COOL: if (tmr_zero) d.state = ST_CHECK;
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{state: ST_IDLE, default: '0};
        else        q <= d;
    end

    osc_meas_timer #(.TW(PRM_W)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .zero_o     (tmr_zero)
    );

    assign mux_idx = q.par ? q.word : ((q.word == '0) ? WRD_W'(q.sel) : REF_IDX);

    osc_meas_mux #(.NUM_OSC(NUM_OSC), .CNT_W(CNT_W), .IDX_W(WRD_W)) u_mux (
        .osc_cnt_i (osc_cnt_i),
        .ref_cnt_i (ref_cnt_i),
        .idx_i     (mux_idx),
        .data_o    (data_o)
    );

    always_comb begin
        cnt_rst_o = (q.state == ST_RINIT) || (q.state == ST_RWAIT);
        active    = cnt_rst_o || (q.state == ST_EVAL);
        osc_en_o  = '0;
        if (cnt_rst_o || (q.state == ST_EVAL && q.par))
            osc_en_o = '1;
        else if (q.state == ST_EVAL)
            osc_en_o = NUM_OSC'(1) << q.sel;
    end

    assign ref_en_o      = active;
    assign data_en_o     = (q.state == ST_SEND) && (q.heat_left == '0);
    assign xfer_permit_o = q.grant && !active;
    assign done_irq_o    = q.irq;

    // Counter reset is only useful with every oscillator running.
    assert_rst_all_en_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_rst_o |-> (&osc_en_o && ref_en_o));

    // Words are only sent with the oscillators stopped.
    assert_send_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        data_en_o |-> (osc_en_o == '0 && !ref_en_o));

    // Serial mode never runs two oscillators in an evaluation window.
    assert_serial_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!q.par && !cnt_rst_o) |-> $onehot0(osc_en_o));

    // Drain permission is withheld while anything oscillates.
    assert_permit_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (|osc_en_o || ref_en_o) |-> !xfer_permit_o);

    // Completion is only flagged out of the check state.
    assert_irq_from_check_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_irq_o) |-> ($past(q.state) == ST_CHECK));

    // The evaluation window is entered from the reset wait.
    assert_eval_after_reset_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(q.state == ST_EVAL)) |-> $past(cnt_rst_o));

endmodule

// File: tb/osc_meas_seq_test.sv
module osc_meas_seq_test;
    localparam int CLK_PERIOD = 10;
    localparam int N  = 32;
    localparam int CW = 32;
    localparam int PW = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start_i = 1'b0;
    logic [2:0]      mode_i = '0;
    logic [PW-1:0]   readouts_i = '0, eval_i = '0, heatup_i = '0, cool_i = '0;
    logic [10:0]     buf_level_i = '0;
    logic [N*CW-1:0] osc_cnt_i;
    logic [CW-1:0]   ref_cnt_i;
    logic [N-1:0]    osc_en_o;
    logic            ref_en_o, cnt_rst_o, data_en_o, xfer_permit_o, done_irq_o;
    logic [CW-1:0]   data_o;

    logic [CW-1:0] cnt [N];
    logic [CW-1:0] ref_cnt;
    logic [CW-1:0] expq [$];
    int checks = 0, fails = 0, cyc = 0;
    int rst_len = 0, ev_len = 0, exp_ev = 1;
    bit serial_run = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    osc_meas_seq uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
        .readouts_i(readouts_i), .eval_i(eval_i), .heatup_i(heatup_i),
        .cool_i(cool_i), .buf_level_i(buf_level_i), .osc_cnt_i(osc_cnt_i),
        .ref_cnt_i(ref_cnt_i), .osc_en_o(osc_en_o), .ref_en_o(ref_en_o),
        .cnt_rst_o(cnt_rst_o), .data_o(data_o), .data_en_o(data_en_o),
        .xfer_permit_o(xfer_permit_o), .done_irq_o(done_irq_o)
    );

    // Behavioural oscillators: oscillator i adds i+3 per clock, reference adds 2.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        for (int i = 0; i < N; i++)
            if (osc_en_o[i]) cnt[i] <= cnt_rst_o ? '0 : cnt[i] + CW'(i + 3);
        if (ref_en_o) ref_cnt <= cnt_rst_o ? '0 : ref_cnt + CW'(2);
    end
    always_comb begin
        for (int i = 0; i < N; i++) osc_cnt_i[i*CW +: CW] = cnt[i];
        ref_cnt_i = ref_cnt;
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
        end
    endtask

    // Per-clock comparison against the reference model.
    always @(negedge clk) if (rst_n) begin
        if (data_en_o) begin
            if (expq.size() == 0) check(0, "R4/R5 extra word", data_o, 0);
            else begin
                logic [CW-1:0] e;
                e = expq.pop_front();
                check(data_o == e, "R4/R5 word", data_o, e);
            end
        end
        if (cnt_rst_o) begin
            rst_len++;
            if (!(&osc_en_o && ref_en_o)) check(0, "R2 enables in reset", osc_en_o, '1);
        end else if (rst_len != 0) begin
            check(rst_len == 17, "R2 reset length", rst_len, 17);
            rst_len = 0;
        end
        if (!cnt_rst_o && ref_en_o) ev_len++;
        else if (!cnt_rst_o && ev_len != 0) begin
            check(ev_len == exp_ev, "R3 eval length", ev_len, exp_ev);
            ev_len = 0;
        end
        if (!cnt_rst_o && serial_run && $countones(osc_en_o) > 1)
            check(0, "R5 one oscillator", $countones(osc_en_o), 1);
        if ((|osc_en_o || ref_en_o) && xfer_permit_o)
            check(0, "R8 permit while running", 1, 0);
    end

    task automatic run(input logic [2:0] m, input int r, input int e, input int h,
                       input int c, input int lvl, input bit poke, input string tag);
        int ee, hh, cc, meas, len, t0, waited;
        ee = (e == 0) ? 1 : e;
        hh = m[1] ? h : 0;
        cc = m[2] ? c : 0;
        meas = m[0] ? (hh + r) : (hh + r) * N;
        len  = 18 + ee + (m[0] ? N + 1 : 2) + cc;
        exp_ev = ee;
        serial_run = !m[0];
        for (int k = 0; k < r; k++) begin
            if (m[0]) begin
                for (int i = 0; i < N; i++) expq.push_back(CW'((i + 3) * ee));
                expq.push_back(CW'(2 * ee));
            end else begin
                for (int i = 0; i < N; i++) begin
                    expq.push_back(CW'((i + 3) * ee));
                    expq.push_back(CW'(2 * ee));
                end
            end
        end
        @(negedge clk);
        mode_i = m; readouts_i = r; eval_i = e; heatup_i = h; cool_i = c;
        buf_level_i = 11'(lvl);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        t0 = cyc;
        if (poke) begin
            repeat (30) @(negedge clk);
            mode_i = ~m; readouts_i = 7; eval_i = 99; heatup_i = 0; cool_i = 50;
            start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
        end
        waited = 0;
        while (!done_irq_o && waited < 40000) begin
            @(negedge clk);
            waited++;
        end
        check(done_irq_o, {tag, " R9 done raised"}, done_irq_o, 1);
        check(cyc - t0 == meas * len + 1, {tag, " R9/R7/R6 campaign length"}, cyc - t0, meas * len + 1);
        check(expq.size() == 0, {tag, " R4/R5/R6 words outstanding"}, expq.size(), 0);
        check(xfer_permit_o == (lvl > 256), {tag, " R8 permit decision"}, xfer_permit_o, lvl > 256);
        repeat (5) @(negedge clk);
        check(done_irq_o, {tag, " R9 done sticky"}, done_irq_o, 1);
        expq.delete();
    endtask

    initial begin
        for (int i = 0; i < N; i++) cnt[i] = CW'(1000 + i);
        ref_cnt = CW'(777);
        repeat (3) @(negedge clk);
        check(osc_en_o == '0 && !ref_en_o, "R1 reset idle enables", osc_en_o, 0);
        check(!data_en_o && !done_irq_o && !cnt_rst_o, "R9 reset outputs", done_irq_o, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        run(3'b001, 2, 10, 0, 0, 100, 0, "par");
        run(3'b110, 1, 5, 1, 3, 257, 0, "serial heat cool");
        run(3'b001, 1, 0, 2, 7, 256, 0, "par eval0 ignored heat cool");
        run(3'b001, 0, 4, 0, 0, 300, 0, "zero readouts");
        run(3'b111, 1, 6, 1, 2, 500, 1, "R1 R10 restart ignored");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 190000);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=finish", cyc);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule